// File: doc/BRIEF.md
# Serial DAC Frame Transmitter

The block feeds an external serial DAC with fixed-length frames. It runs entirely in one fast system clock domain. A divide counter inside the block produces a slow serial clock, so no logic is clocked by a derived clock. The frame payload arrives as three 16-bit words over a valid/ready interface. The block assembles them into one frame and shifts it out MSB first. A tag pulse marks the bit period that carries the last bit of each frame.

The payload buffer is separate from the output shift register. While one frame is on the wire, the words for the next frame can already be accepted, and frames then follow each other with no gap. If the next frame is not complete when a frame ends, the data and tag lines rest low and the serial clock keeps running.

Top module: `serial_dac_tx`

## Requirements
- R1: The serial clock has a period of DIV system cycles (default 100). It is high for DIV/2 cycles and low for DIV/2 cycles. Reset leaves it high, and it first falls DIV/2 cycles after reset is released.
- R2: Serial data and tag change only on the system clock edge where the serial clock falls. Both are therefore stable across every rising edge of the serial clock, which is where the DAC samples.
- R3: A frame is FRAME_BITS (default 49) bits, sent MSB first. Bits 15:0 hold the first accepted word, bits 31:16 the second and bits 47:32 the third.
- R4: The top frame bit (bit 48) is the pad value set by the PAD_BIT parameter.
- R5: The tag is high for exactly one serial clock period per frame: the period that carries frame bit 0. It is never high in any other period.
- R6: When the next frame's three words are already held at the moment a frame's last bit period ends, the next frame's bit 48 follows in the very next period. Consecutive tags are then exactly FRAME_BITS periods apart.
- R7: When no complete frame is waiting, serial data and tag stay low while the serial clock keeps toggling.
- R8: Word ready is high only while enable is high and fewer than three words of the next frame are held. A word is taken on each cycle where valid and ready are both high. With enable low, no word is taken, whatever valid does.
- R9: Busy goes high the cycle after the first word of a frame is accepted. It stays high until the bit-0 period of the last frame ends.
- R10: A synchronous reset clears the divider, the frame in flight, the tag and any partly filled payload. After reset, the first three accepted words form the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Allows words to be accepted |
| word_data | input | 16 | Payload word |
| word_valid | input | 1 | Payload word present |
| word_ready | output | 1 | Block can take a word this cycle |
| sclk | output | 1 | Serial clock to the DAC |
| sdata | output | 1 | Serial data, MSB first |
| tag | output | 1 | High during the bit-0 period of a frame |
| busy | output | 1 | Frame being collected or sent |

## Verification
Busy responds one system cycle after the accepting edge. Serial data and tag move on the same edge as the serial clock's fall. The DAC-side value of each bit is due DIV/2 cycles later, at the serial clock's rise.

The bench samples every output on the falling system clock edge. It captures data and tag only at the sampled serial clock rise, as the DAC would, and rebuilds each frame from those captures. It checks every high and low phase of the serial clock for a length of exactly DIV/2 samples. After the final tag it allows a margin of 60 cycles before it expects busy to drop.

// File: rtl/serial_dac_tx.sv
module serial_dac_tx #(
  parameter int DIV        = 100,
  parameter int FRAME_BITS = 49,
  parameter int WORD_W     = 16,
  parameter int NWORDS     = 3,
  parameter bit PAD_BIT    = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [WORD_W-1:0] word_data,
  input  logic              word_valid,
  output logic              word_ready,
  output logic              sclk,
  output logic              sdata,
  output logic              tag,
  output logic              busy
);
  localparam int HALF  = DIV / 2;
  localparam int DIV_W = $clog2(DIV);
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam int WC_W  = $clog2(NWORDS + 1);
  localparam int PAY_W = WORD_W * NWORDS;
  localparam int PAD_W = FRAME_BITS - PAY_W;

  logic [DIV_W-1:0]      div_cnt;
  logic [DIV_W-1:0]      div_nxt;
  logic                  sclk_r;
  logic [WC_W-1:0]       wcnt;
  logic [PAY_W-1:0]      payload;
  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0]      bits_left;
  logic                  tag_r;
  logic                  step;
  logic                  take;
  logic                  full;

  assign div_nxt    = (div_cnt == DIV_W'(DIV - 1)) ? '0 : div_cnt + 1'b1;
  assign step       = (div_cnt == DIV_W'(HALF - 1));
  assign full       = (wcnt == WC_W'(NWORDS));
  assign word_ready = en && !full;
  assign take       = word_ready && word_valid;

  assign sclk  = sclk_r;
  assign sdata = shreg[FRAME_BITS-1];
  assign tag   = tag_r;
  assign busy  = (wcnt != '0) || (bits_left != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cnt   <= '0;
      sclk_r    <= 1'b1;
      wcnt      <= '0;
      payload   <= '0;
      shreg     <= '0;
      bits_left <= '0;
      tag_r     <= 1'b0;
    end else begin
      div_cnt <= div_nxt;
      sclk_r  <= (div_nxt < DIV_W'(HALF));

      if (take) begin
        for (int i = 0; i < NWORDS; i++)
          if (wcnt == WC_W'(i)) payload[i*WORD_W +: WORD_W] <= word_data;
        wcnt <= wcnt + 1'b1;
      end

      if (step) begin
        if (bits_left > CNT_W'(1)) begin
          shreg     <= {shreg[FRAME_BITS-2:0], 1'b0};
          bits_left <= bits_left - 1'b1;
          tag_r     <= (bits_left == CNT_W'(2));
        end else if (full) begin
          shreg     <= {{PAD_W{PAD_BIT}}, payload};
          bits_left <= CNT_W'(FRAME_BITS);
          wcnt      <= '0;
          tag_r     <= 1'b0;
        end else begin
          shreg     <= '0;
          bits_left <= '0;
          tag_r     <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/serial_dac_tx_checks.sv
module serial_dac_tx_checks (
  input logic clk,
  input logic rst,
  input logic en,
  input logic word_ready,
  input logic sclk,
  input logic sdata,
  input logic tag,
  input logic busy
);
  p_data_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(sdata) |-> $fell(sclk));

  p_tag_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    !$stable(tag) |-> $fell(sclk));

  p_low_phase_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(sclk) |=> !sclk);

  p_ready_needs_en_r8: assert property (@(posedge clk) disable iff (rst)
    word_ready |-> en);

  p_tag_in_frame_r5: assert property (@(posedge clk) disable iff (rst)
    tag |-> busy);

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!sdata && !tag));
endmodule

bind serial_dac_tx serial_dac_tx_checks u_checks (
  .clk(clk), .rst(rst), .en(en), .word_ready(word_ready),
  .sclk(sclk), .sdata(sdata), .tag(tag), .busy(busy)
);

// File: tb/sim_serial_dac_tx.sv
module sim_serial_dac_tx;
  localparam int  FB    = 49;
  localparam int  HALFP = 50;
  localparam bit  PAD   = 1'b1;
  localparam int  LIMIT = 190000;

  logic clk = 1'b0;
  logic rst, en, word_valid;
  logic [15:0] word_data;
  logic word_ready, sclk, sdata, tag, busy;

  always #5 clk = ~clk;

  serial_dac_tx #(.PAD_BIT(PAD)) u0 (
    .clk(clk), .rst(rst), .en(en), .word_data(word_data), .word_valid(word_valid),
    .word_ready(word_ready), .sclk(sclk), .sdata(sdata), .tag(tag), .busy(busy)
  );

  int checks = 0;
  int errors = 0;
  logic [FB-1:0] expq[$];
  logic [15:0] wbuf[3];
  int widx = 0;
  bit sat_mode = 0;
  int sat_tags = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [FB-1:0] mk_frame(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    return {PAD, c, b, a};
  endfunction

  // monitor: DAC-side view, sampled away from the active edge
  int cyc = 0;
  int run = 0;
  bit have_edge = 0;
  logic prev_sclk = 1'b1;
  logic prev_tag_cap = 1'b0;
  logic [FB-1:0] hist = '0;
  int bits_since = 0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > LIMIT) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cyc, LIMIT);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rst) begin
      prev_sclk = 1'b1; have_edge = 0; run = 0; hist = '0;
      bits_since = 0; prev_tag_cap = 1'b0;
    end else begin
      run++;
      if (sclk != prev_sclk) begin
        if (have_edge) chk(run == HALFP, "R1 sclk phase length", run, HALFP);
        have_edge = 1; run = 0;
        if (sclk) begin
          hist = {hist[FB-2:0], sdata};
          bits_since++;
          if (tag) begin
            chk(!prev_tag_cap, "R5 tag one period only", 1, 0);
            if (expq.size() == 0) chk(0, "R5 tag without frame", 1, 0);
            else begin
              chk(hist == expq[0], "R3 frame content", hist, expq[0]);
              chk(hist[FB-1] == PAD, "R4 pad bit", hist[FB-1], PAD);
              void'(expq.pop_front());
            end
            if (sat_mode) begin
              if (sat_tags > 0) chk(bits_since == FB, "R6 back-to-back spacing", bits_since, FB);
              sat_tags++;
            end
            bits_since = 0;
          end
          prev_tag_cap = tag;
        end
      end
      prev_sclk = sclk;
    end
  end

  task automatic send_word(input logic [15:0] d);
    bit acc;
    word_data = d;
    word_valid = 1'b1;
    do begin
      acc = word_ready;
      @(negedge clk);
    end while (!acc);
    word_valid = 1'b0;
    wbuf[widx] = d;
    widx++;
    if (widx == 3) begin
      expq.push_back(mk_frame(wbuf[0], wbuf[1], wbuf[2]));
      widx = 0;
    end
  endtask

  task automatic wait_drain();
    while (expq.size() != 0) @(negedge clk);
    chk(busy == 1'b1, "R9 busy during last bit", busy, 1);
    repeat (60) @(negedge clk);
    chk(busy == 1'b0, "R9 busy after last bit", busy, 0);
  endtask

  initial begin
    bit ok;
    void'($urandom(32'd4242));
    rst = 1'b1; en = 1'b1; word_valid = 1'b0; word_data = '0;
    repeat (5) @(negedge clk);
    chk(sclk == 1'b1, "R10 reset sclk", sclk, 1);
    chk(sdata == 1'b0, "R10 reset sdata", sdata, 0);
    chk(tag == 1'b0, "R10 reset tag", tag, 0);
    chk(busy == 1'b0, "R10 reset busy", busy, 0);
    chk(word_ready == 1'b1, "R10 reset ready", word_ready, 1);
    rst = 1'b0;

    // R8: enable low blocks word acceptance
    en = 1'b0; word_valid = 1'b1; word_data = 16'hDEAD;
    ok = 1;
    repeat (300) begin
      @(negedge clk);
      if (word_ready || busy || sdata || tag) ok = 0;
    end
    chk(ok, "R8 enable low takes nothing (R7 idle quiet)", ok, 1);
    word_valid = 1'b0; en = 1'b1;
    @(negedge clk);

    // R9: busy the cycle after first accepted word
    send_word(16'h0001);
    chk(busy == 1'b1, "R9 busy after first word", busy, 1);
    send_word(16'h8000);
    send_word(16'hFFFF);

    // saturated random stream
    sat_mode = 1; sat_tags = 0;
    for (int f = 0; f < 8; f++) begin
      for (int w = 0; w < 3; w++) begin
        repeat ($urandom % 20) @(negedge clk);
        send_word(16'($urandom));
      end
    end
    wait_drain();
    sat_mode = 0;

    // R7: long idle with nothing waiting
    ok = 1;
    repeat (6000) begin
      @(negedge clk);
      if (sdata || tag) ok = 0;
    end
    chk(ok, "R7 idle line quiet", ok, 1);

    send_word(16'h5A5A); send_word(16'h0F0F); send_word(16'hC3C3);
    wait_drain();

    // R10: reset mid-frame with a partial next frame
    send_word(16'h1111); send_word(16'h2222); send_word(16'h3333);
    repeat (1000) @(negedge clk);
    send_word(16'h4444); send_word(16'h5555);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    expq.delete(); widx = 0;
    chk(sdata == 1'b0 && tag == 1'b0 && busy == 1'b0 && sclk == 1'b1,
        "R10 mid-frame reset outputs", {sdata, tag, busy, sclk}, 4'b0001);
    rst = 1'b0;
    send_word(16'hABCD); send_word(16'h1357); send_word(16'h2468);
    wait_drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule